// File: doc/BRIEF.md
# Leading-Run Weight Squeezer

This block turns signed 8-bit fixed-point weights into a 5-bit reduced-precision word for a multiply array, plus a small side-channel word for the few weights that cannot be shrunk without loss. A weight whose top four bits are all equal (all zeros or all ones) carries no information in three of those bits. It is therefore squeezed into a sign bit plus its middle three bits, and its lowest bit is dropped. Any other weight keeps its top nibble in the reduced word. Its middle three bits, with a copy of its sign, are sent out as a compensation word and marked valid.

A leading tag bit in every reduced word tells downstream logic which encoding is in use. The block works on a vector of lanes, eight by default, to match memories that return eight entries per access. A mode input lets the whole vector be encoded, or lane 0 alone. The result goes through an optional output register that loads only on accepted input, so the encoded words sit stable between accesses.

Top module: `weight_squeeze`

## Requirements
- R1: A lane's weight is classed as a run weight exactly when its bits [7:4] are 0000 or 1111. For example, 0x0D and 0xF6 are run weights, and 0x10 and 0xEF are not.
- R2: For a run weight w, the 5-bit reduced word is {0, w[7], w[3:1]}, with bit 4 as the tag.
- R3: For a non-run weight w, the reduced word is {1, w[7:4]}.
- R4: For a non-run weight, the lane's comp_valid bit is 1 and its 4-bit compensation word is {w[7], w[3:1]}, with the sign in bit 3.
- R5: For a run weight, comp_valid is 0 and the compensation word is 0000.
- R6: Lane i takes weights_in[8i+7:8i] and drives red_out[5i+4:5i], comp_out[4i+3:4i] and comp_valid[i], independently of the other lanes.
- R7: When batch_mode is 0, only lane 0 is encoded. Every other lane outputs an all-zero reduced word, an all-zero compensation word and comp_valid 0.
- R8: With the default registered output, the results of an input accepted with in_valid appear one clock later with out_valid 1. A cycle with in_valid 0 leaves red_out, comp_out and comp_valid unchanged and drives out_valid 0 on the next clock.
- R9: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| in_valid | input | 1 | A weight vector is presented this cycle |
| batch_mode | input | 1 | 1: encode all lanes; 0: encode lane 0 only |
| weights_in | input | LANES*8 | Packed signed weights, lane i at bits [8i+7:8i] |
| out_valid | output | 1 | Outputs hold a newly encoded vector |
| red_out | output | LANES*5 | Reduced words, tag in bit 4 of each lane |
| comp_out | output | LANES*4 | Compensation words, sign in bit 3 of each lane |
| comp_valid | output | LANES | Per-lane flag: the weight needs compensation |

## Verification
Two functions can act in the same cycle: lane masking by batch mode and the generation of a compensation word. An upper lane can hold a non-run weight that would raise comp_valid while batch_mode is 0, and the mask must win. The random stimulus creates this case often, by drawing batch_mode at random and biasing the weights so that roughly half of the lanes are non-run. A bench model checks every lane in each such cycle: lane 0 must still be encoded, and every masked lane must show all-zero words with comp_valid 0.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    localparam int W_BITS   = 8;
    localparam int RUN_LEN  = 4;
    localparam int MID_BITS = W_BITS - RUN_LEN - 1;
    localparam int RED_BITS = 1 + RUN_LEN;
    localparam int CMP_BITS = 1 + MID_BITS;
    localparam int LANE_OUT = RED_BITS + CMP_BITS + 1;

    typedef struct packed {
        logic                comp_vld;
        logic [CMP_BITS-1:0] comp;
        logic [RED_BITS-1:0] red;
    } lane_res_t;
endpackage

// File: rtl/wsq_lane.sv
module wsq_lane
    import wsq_pkg::*;
(
    input  logic [W_BITS-1:0] weight,
    input  logic              enable,
    output lane_res_t         res
);
    logic [RUN_LEN-1:0]  top_bits;
    logic [MID_BITS-1:0] mid_bits;
    logic                sign_bit;
    logic                is_run;
    logic                lsb_unused;

    assign top_bits   = weight[W_BITS-1 -: RUN_LEN];
    assign mid_bits   = weight[MID_BITS:1];
    assign sign_bit   = weight[W_BITS-1];
    assign lsb_unused = weight[0];
    assign is_run     = (top_bits == '0) || (top_bits == '1);

    always_comb begin
        res = '0;
        if (enable) begin
            if (is_run) begin
                res.red = {1'b0, sign_bit, mid_bits};
            end else begin
                res.red      = {1'b1, top_bits};
                res.comp     = {sign_bit, mid_bits};
                res.comp_vld = 1'b1;
            end
        end
    end

    always_comb begin
        if (!enable) begin
            assert_masked_zero_R7: assert (res == '0);
        end
    end
endmodule

// File: rtl/wsq_out_stage.sv
module wsq_out_stage #(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] d,
    output logic             out_valid,
    output logic [WIDTH-1:0] q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q         <= '0;
                    out_valid <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        q <= d;
                    end
                end
            end

            assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(in_valid) |-> $stable(q));
            assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(in_valid) |-> out_valid);
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign q              = d;
            assign out_valid      = in_valid;
        end
    endgenerate
endmodule

// File: rtl/weight_squeeze.sv
module weight_squeeze
    import wsq_pkg::*;
#(
    parameter int LANES   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  batch_mode,
    input  logic [LANES*8-1:0]    weights_in,
    output logic                  out_valid,
    output logic [LANES*5-1:0]    red_out,
    output logic [LANES*4-1:0]    comp_out,
    output logic [LANES-1:0]      comp_valid
);
    localparam int BUS_W = LANES * LANE_OUT;

    lane_res_t [LANES-1:0] lane_res;
    lane_res_t [LANES-1:0] lane_q;
    logic [BUS_W-1:0]      bus_d;
    logic [BUS_W-1:0]      bus_q;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            wsq_lane u_lane (
                .weight (weights_in[i*W_BITS +: W_BITS]),
                .enable ((i == 0) || batch_mode),
                .res    (lane_res[i])
            );
            assign red_out[i*RED_BITS +: RED_BITS]  = lane_q[i].red;
            assign comp_out[i*CMP_BITS +: CMP_BITS] = lane_q[i].comp;
            assign comp_valid[i]                    = lane_q[i].comp_vld;

            assert_tag_vs_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && (i == 0 || red_out[i*RED_BITS +: RED_BITS] != '0))
                    |-> (red_out[i*RED_BITS + RED_BITS - 1] == comp_valid[i]));
            assert_comp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !comp_valid[i] |-> (comp_out[i*CMP_BITS +: CMP_BITS] == '0));
        end
    endgenerate

    assign bus_d  = lane_res;
    assign lane_q = bus_q;

    wsq_out_stage #(
        .WIDTH   (BUS_W),
        .REG_OUT (REG_OUT)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (bus_d),
        .out_valid (out_valid),
        .q         (bus_q)
    );

    generate
        if (REG_OUT) begin : g_chk
            assert_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(in_valid) |-> (red_out[RED_BITS-1] ==
                    !($past(weights_in[7:4]) == 4'h0 || $past(weights_in[7:4]) == 4'hF)));
            assert_run_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(in_valid) && !red_out[RED_BITS-1])
                    |-> (red_out[3:0] == {$past(weights_in[7]), $past(weights_in[3:1])}));
            assert_plain_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(in_valid) && red_out[RED_BITS-1])
                    |-> (red_out[3:0] == $past(weights_in[7:4])));
        end
    endgenerate
endmodule

// File: tb/weight_squeeze_tb.sv
module weight_squeeze_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  batch_mode = 1'b0;
    logic [LANES*8-1:0]    weights_in = '0;
    logic                  out_valid;
    logic [LANES*5-1:0]    red_out;
    logic [LANES*4-1:0]    comp_out;
    logic [LANES-1:0]      comp_valid;

    int checks = 0;
    int errors = 0;
    logic [LANES*10-1:0] last_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    weight_squeeze #(.LANES(LANES), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .batch_mode(batch_mode),
        .weights_in(weights_in), .out_valid(out_valid), .red_out(red_out),
        .comp_out(comp_out), .comp_valid(comp_valid)
    );

    // Expected {comp_valid, comp[3:0], red[4:0]} for one lane.
    function automatic logic [9:0] model(input logic [7:0] w, input logic en);
        logic [9:0] r;
        r = '0;
        if (en) begin
            if (w[7:4] == 4'h0 || w[7:4] == 4'hF) r = {1'b0, 4'h0, 1'b0, w[7], w[3:1]};
            else                                  r = {1'b1, w[7], w[3:1], 1'b1, w[7:4]};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_lanes(input string req, input logic [LANES*10-1:0] exp);
        for (int i = 0; i < LANES; i++) begin
            logic [9:0] e;
            e = exp[i*10 +: 10];
            check(req, {22'd0, comp_valid[i], comp_out[i*4 +: 4], red_out[i*5 +: 5]}, {22'd0, e});
        end
    endtask

    task automatic apply(input string req, input logic [LANES*8-1:0] w, input logic mode);
        logic [LANES*10-1:0] exp;
        @(negedge clk);
        in_valid   = 1'b1;
        batch_mode = mode;
        weights_in = w;
        for (int i = 0; i < LANES; i++) exp[i*10 +: 10] = model(w[i*8 +: 8], (i == 0) || mode);
        @(posedge clk);
        #1;
        check({req, " R8 valid"}, {31'd0, out_valid}, 32'd1);
        check_lanes(req, exp);
        last_exp = exp;
    endtask

    function automatic logic [7:0] rand_weight();
        logic [7:0] w;
        w = 8'($urandom);
        if ($urandom_range(1, 0) == 1) w[7:4] = w[7] ? 4'hF : 4'h0;
        return w;
    endfunction

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset red", red_out, '0);
        check("R9 reset comp", {comp_valid, comp_out[23:0]}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: run weights 0x0D and 0xF6; R3/R4: 0x10 and 0xEF; extremes.
        apply("R1 R2 R3 R4 directed", 64'h80_7F_EF_10_FF_00_F6_0D, 1'b1);
        check("R1 R2 0x0D", {27'd0, red_out[4:0]}, 32'h06);
        check("R1 R2 0xF6", {27'd0, red_out[9:5]}, 32'h0B);
        check("R3 R4 0x10", {23'd0, comp_valid[4], red_out[24:20], comp_out[19:16]}, {23'd0, 1'b1, 5'h11, 4'h0});
        check("R3 R4 0x80", {23'd0, comp_valid[7], red_out[39:35], comp_out[31:28]}, {23'd0, 1'b1, 5'h18, 4'h8});
        check("R5 run comp", {24'd0, comp_out[7:0]}, 32'd0);

        // R7: masked upper lanes with non-run weights.
        apply("R7 masked", 64'h80_7F_EF_10_40_B3_5A_C1, 1'b0);
        check("R7 upper valid", {24'd0, comp_valid[7:1], 1'b0}, 32'd0);

        // R6: one non-run lane walking across a field of runs.
        for (int k = 0; k < LANES; k++) begin
            logic [LANES*8-1:0] w;
            w = {LANES{8'h03}};
            w[k*8 +: 8] = 8'hA5;
            apply("R6 walking lane", w, 1'b1);
        end

        // R8: hold with in_valid low.
        @(negedge clk);
        in_valid   = 1'b0;
        weights_in = {LANES{8'h5A}};
        batch_mode = 1'b1;
        @(posedge clk);
        #1;
        check("R8 idle valid", {31'd0, out_valid}, 32'd0);
        check_lanes("R8 hold", last_exp);

        for (int n = 0; n < 400; n++) begin
            logic [LANES*8-1:0] w;
            for (int i = 0; i < LANES; i++) w[i*8 +: 8] = rand_weight();
            apply("R1 R2 R3 R4 R5 R6 R7 random", w, 1'($urandom_range(1, 0)));
        end

        // R9: reset clears a loaded register.
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R9 re-reset", {comp_valid, comp_out[23:0]}, '0);
        check("R9 re-reset red", red_out, '0);
        report();
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end
endmodule